// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

This block collects level-sensitive interrupt lines, grouped in banks of 32, and presents two interrupt outputs to a processor: a normal output and a fast output. Each line has a mask bit and a software-trigger bit, both changed through write-one set and clear words. Each line also has a level word that sets a 6-bit priority and steers the line to one of the two outputs. For each output the controller picks the winning line among the lines that are pending, unmasked and below an optional priority threshold. It stores the line's number and priority and raises the output.

An output stays raised, and its stored number and priority stay frozen, until software writes an acknowledge bit in the control word. The next cycle starts a fresh selection. If software reads the stored number after the winning line has stopped pending on that output, the upper bits of the number and priority words read as all ones. This tells software to treat the interrupt as spurious.

Top module: `intc_top`

## Requirements
- R1: Line n sits in bank n/32 at bit n%32. Each bank has a group of eight words at word address 0x10+8*bank. Offset 0 is raw input, 1 is mask, 2 is mask-clear, 3 is mask-set, 4 is soft-set, 5 is soft-clear, 6 is pending-normal and 7 is pending-fast. A read at offset 2 or 3 returns the mask. A read at offset 4 or 5 returns the soft-trigger bits.
- R2: A 1 written to a mask-clear bit clears that mask bit. A 1 written to a mask-set bit sets it. A write to offset 1 loads the mask word directly. Bits written as 0 keep their value. After reset every mask bit is 1.
- R3: A 1 written to a soft-set bit sets that soft-trigger bit. A 1 written to a soft-clear bit clears it. Bits written as 0 keep their value. After reset all soft-trigger bits are 0.
- R4: The raw word reads (hardware input OR soft-trigger bit). Pending-normal reads raw AND NOT mask AND NOT steer. Pending-fast reads raw AND NOT mask AND steer.
- R5: The level word of line n is at word address 0x80+n. Bit 0 is steer (1 = fast output, 0 = normal output) and bits 7:2 are the priority. Bit 1 and bits 31:8 read 0. The reset value is 0.
- R6: For each output, the winner is the line with the numerically lowest priority among the qualifying lines steered to that output. On equal priority the lower line number wins.
- R7: The threshold word is at 0x05 and resets to 0xFF. The value 0xFF turns filtering off. Any other value lets a line qualify only if its priority is below the threshold.
- R8: When an output is not held and a qualifying line exists at a clock edge, that edge stores the winner and raises the output. The output is visible one cycle after the state change that made the line qualify. The number words are at 0x00 (normal) and 0x01 (fast) and hold the line in bits 6:0. The priority words are at 0x02 and 0x03 and hold the priority in bits 5:0.
- R9: While an output is held, its output and its stored number and priority do not change. A write to the control word 0x04 with bit 0 set releases the normal output. Bit 1 releases the fast output. A release lowers the output at that edge, and a new winner can be stored at the next edge. An acknowledge for one output does not affect the other.
- R10: If the stored line is not pending on its output, bits 31:7 of the number word and bits 31:6 of the priority word read as ones. Otherwise they read as zeros.
- R11: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwIn | input | NUM_BANKS*32 | Level-sensitive hardware interrupt lines |
| regAddr | input | 8 | Word address of the register access |
| regWrEn | input | 1 | Write strobe for the addressed word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the addressed word (combinational) |
| irqOut | output | 1 | Normal interrupt output |
| fiqOut | output | 1 | Fast interrupt output |

## Verification
The assertions assume the following about the register port:
- It makes at most one write per cycle.
- The inputs and write data are stable around the rising edge.
- An acknowledge is only meaningful while the matching output is held.

The stimulus changes every input at the falling clock edge and issues one write per two cycles. Each selection is run from a full, freshly written configuration. The configurations come from a pseudo-random sweep that mixes narrow priority ranges, which force ties, with thresholds that are off, partial or blocking. The bench's reference model predicts the outputs only after an acknowledge has settled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_BITS = 32;
  localparam int PRIO_W = 6;
  localparam int NUM_W = 7;

  localparam logic [7:0] A_NUM_IRQ = 8'h00;
  localparam logic [7:0] A_NUM_FIQ = 8'h01;
  localparam logic [7:0] A_PRI_IRQ = 8'h02;
  localparam logic [7:0] A_PRI_FIQ = 8'h03;
  localparam logic [7:0] A_CTRL    = 8'h04;
  localparam logic [7:0] A_THR     = 8'h05;

  typedef enum logic [2:0] {
    BK_RAW  = 3'd0,
    BK_MASK = 3'd1,
    BK_MCLR = 3'd2,
    BK_MSET = 3'd3,
    BK_SSET = 3'd4,
    BK_SCLR = 3'd5,
    BK_PIRQ = 3'd6,
    BK_PFIQ = 3'd7
  } bankReg_e;

  typedef struct packed {
    logic       maskWr;
    logic       maskSet;
    logic       maskClr;
    logic       swiSet;
    logic       swiClr;
    logic       levelWr;
    logic       thrWr;
    logic [1:0] ack;
    logic [1:0] latch;
    logic       bankHit;
    logic       levelHit;
    logic [1:0] bankSel;
    bankReg_e   bankReg;
    logic [6:0] lineSel;
  } strobe_t;
endpackage

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  input  logic [1:0]  anyValid,
  output strobe_t     strb,
  output logic [1:0]  holdQ
);
  localparam int LINES = NUM_BANKS * BANK_BITS;

  logic [2:0] bankIdx;
  logic       bankHit;
  logic       levelHit;

  assign bankIdx  = regAddr[5:3] - 3'd2;
  assign bankHit  = (regAddr[7:6] == 2'b00) && (regAddr[5:4] != 2'b00) &&
                    (int'(bankIdx) < NUM_BANKS);
  assign levelHit = regAddr[7] && (int'(regAddr[6:0]) < LINES);

  always_comb begin
    strb          = '0;
    strb.bankHit  = bankHit;
    strb.levelHit = levelHit;
    strb.bankSel  = bankIdx[1:0];
    strb.bankReg  = bankReg_e'(regAddr[2:0]);
    strb.lineSel  = regAddr[6:0];
    if (regWrEn && bankHit) begin
      case (bankReg_e'(regAddr[2:0]))
        BK_MASK: strb.maskWr  = 1'b1;
        BK_MCLR: strb.maskClr = 1'b1;
        BK_MSET: strb.maskSet = 1'b1;
        BK_SSET: strb.swiSet  = 1'b1;
        BK_SCLR: strb.swiClr  = 1'b1;
        default: ;
      endcase
    end
    strb.levelWr = regWrEn && levelHit;
    strb.thrWr   = regWrEn && (regAddr == A_THR);
    strb.ack     = (regWrEn && (regAddr == A_CTRL)) ? regWrData[1:0] : 2'b00;
    strb.latch   = ~holdQ & anyValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 2'b00;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (holdQ[p] && strb.ack[p]) holdQ[p] <= 1'b0;
        else if (strb.latch[p])      holdQ[p] <= 1'b1;
      end
    end
  end

  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.maskWr, strb.maskSet, strb.maskClr, strb.swiSet,
              strb.swiClr, strb.levelWr, strb.thrWr}));

  for (genvar p = 0; p < 2; p++) begin : g_chk
    assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rstN)
      holdQ[p] && strb.ack[p] |=> !holdQ[p]);
    assert_hold_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
      holdQ[p] && !strb.ack[p] |=> holdQ[p]);
    assert_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
      !holdQ[p] && anyValid[p] |=> holdQ[p]);
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strb,
  input  logic [31:0]                     regWrData,
  input  logic [7:0]                      regAddr,
  input  logic [NUM_BANKS*BANK_BITS-1:0]  hwIn,
  output logic [31:0]                     regRdData,
  output logic [1:0]                      anyValid
);
  localparam int LINES  = NUM_BANKS * BANK_BITS;
  localparam int LINE_W = $clog2(LINES);

  logic [LINES-1:0]  maskQ, swiQ, steerQ, rawV;
  logic [PRIO_W-1:0] prioQ [LINES];
  logic [7:0]        thrQ;
  logic [1:0][NUM_W-1:0]  winNumQ, bestNum;
  logic [1:0][PRIO_W-1:0] winPrioQ, bestPrio;
  logic [1:0][LINES-1:0]  pend;
  logic [1:0]             spur;
  int                     bankBase;
  logic [LINE_W-1:0]      lineIdx;

  assign bankBase = int'(strb.bankSel) * BANK_BITS;
  assign lineIdx  = strb.lineSel[LINE_W-1:0];
  assign rawV     = hwIn | swiQ;
  assign pend[0]  = rawV & ~maskQ & ~steerQ;
  assign pend[1]  = rawV & ~maskQ & steerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      swiQ   <= '0;
      steerQ <= '0;
      thrQ   <= 8'hFF;
      for (int i = 0; i < LINES; i++) prioQ[i] <= '0;
    end else begin
      if (strb.maskWr)  maskQ[bankBase +: BANK_BITS] <= regWrData;
      if (strb.maskSet) maskQ[bankBase +: BANK_BITS] <= maskQ[bankBase +: BANK_BITS] | regWrData;
      if (strb.maskClr) maskQ[bankBase +: BANK_BITS] <= maskQ[bankBase +: BANK_BITS] & ~regWrData;
      if (strb.swiSet)  swiQ[bankBase +: BANK_BITS]  <= swiQ[bankBase +: BANK_BITS] | regWrData;
      if (strb.swiClr)  swiQ[bankBase +: BANK_BITS]  <= swiQ[bankBase +: BANK_BITS] & ~regWrData;
      if (strb.levelWr) begin
        steerQ[lineIdx] <= regWrData[0];
        prioQ[lineIdx]  <= regWrData[7:2];
      end
      if (strb.thrWr) thrQ <= regWrData[7:0];
    end
  end

  // One sorter per output; the steer value selects which lines it sees.
  for (genvar p = 0; p < 2; p++) begin : g_sort
    logic [LINES-1:0]  cand;
    logic              fnd;
    logic [LINE_W-1:0] bN;
    logic [PRIO_W-1:0] bP;

    always_comb begin
      for (int i = 0; i < LINES; i++)
        cand[i] = pend[p][i] && ((thrQ == 8'hFF) || ({2'b00, prioQ[i]} < thrQ));
    end

    always_comb begin
      fnd = 1'b0;
      bN  = '0;
      bP  = '1;
      for (int i = 0; i < LINES; i++) begin
        if (cand[i] && (!fnd || (prioQ[i] < bP))) begin
          fnd = 1'b1;
          bP  = prioQ[i];
          bN  = LINE_W'(i);
        end
      end
    end

    assign anyValid[p] = fnd;
    assign bestNum[p]  = NUM_W'(bN);
    assign bestPrio[p] = bP;
    assign spur[p]     = !pend[p][winNumQ[p][LINE_W-1:0]];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winNumQ[p]  <= '0;
        winPrioQ[p] <= '0;
      end else if (strb.latch[p]) begin
        winNumQ[p]  <= bestNum[p];
        winPrioQ[p] <= bestPrio[p];
      end
    end

    assert_keep_winner_R9: assert property (@(posedge clk) disable iff (!rstN)
      !strb.latch[p] |=> $stable(winNumQ[p]) && $stable(winPrioQ[p]));
    assert_thr_ok_R7: assert property (@(posedge clk) disable iff (!rstN)
      strb.latch[p] && (thrQ != 8'hFF) |=> ({2'b00, winPrioQ[p]} < $past(thrQ)));
    assert_line_range_R6: assert property (@(posedge clk) disable iff (!rstN)
      strb.latch[p] |=> (int'(winNumQ[p]) < LINES));
  end

  always_comb begin
    logic [BANK_BITS-1:0] bankRd;
    case (strb.bankReg)
      BK_RAW:                   bankRd = rawV[bankBase +: BANK_BITS];
      BK_MASK, BK_MCLR, BK_MSET: bankRd = maskQ[bankBase +: BANK_BITS];
      BK_SSET, BK_SCLR:         bankRd = swiQ[bankBase +: BANK_BITS];
      BK_PIRQ:                  bankRd = pend[0][bankBase +: BANK_BITS];
      default:                  bankRd = pend[1][bankBase +: BANK_BITS];
    endcase
    regRdData = '0;
    if (strb.bankHit)       regRdData = bankRd;
    else if (strb.levelHit) regRdData = {24'd0, prioQ[lineIdx], 1'b0, steerQ[lineIdx]};
    else begin
      case (regAddr)
        A_NUM_IRQ: regRdData = {{(32-NUM_W){spur[0]}}, winNumQ[0]};
        A_NUM_FIQ: regRdData = {{(32-NUM_W){spur[1]}}, winNumQ[1]};
        A_PRI_IRQ: regRdData = {{(32-PRIO_W){spur[0]}}, winPrioQ[0]};
        A_PRI_FIQ: regRdData = {{(32-PRIO_W){spur[1]}}, winPrioQ[1]};
        A_THR:     regRdData = {24'd0, thrQ};
        default:   regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_BANKS*BANK_BITS-1:0] hwIn,
  input  logic [7:0]                     regAddr,
  input  logic                           regWrEn,
  input  logic [31:0]                    regWrData,
  output logic [31:0]                    regRdData,
  output logic                           irqOut,
  output logic                           fiqOut
);
  strobe_t    strb;
  logic [1:0] holdQ;
  logic [1:0] anyValid;

  initial begin
    if (NUM_BANKS < 1 || NUM_BANKS > 4) $error("NUM_BANKS must be 1 to 4");
  end

  intc_control #(.NUM_BANKS(NUM_BANKS)) i_control (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .anyValid(anyValid), .strb(strb), .holdQ(holdQ)
  );

  intc_datapath #(.NUM_BANKS(NUM_BANKS)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regAddr(regAddr), .hwIn(hwIn), .regRdData(regRdData), .anyValid(anyValid)
  );

  assign irqOut = holdQ[0];
  assign fiqOut = holdQ[1];
endmodule

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
  localparam int NB = 2;
  localparam int NL = NB * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] hwIn = '0;
  logic [7:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqOut, fiqOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [NL-1:0] mMask = '1, mSwi = '0, mSteer = '0;
  int            mPrio [NL];
  int            mThr = 255;
  logic [31:0]   seed = 32'h1234_5678;

  always #5 clk = ~clk;

  intc_top #(.NUM_BANKS(NB)) i_intc_top (
    .clk(clk), .rstN(rstN), .hwIn(hwIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [7:0] bAddr(input int b, input int k);
    return 8'(8'h10 + b * 8 + k);
  endfunction

  task automatic wrLevel(input int i, input bit st, input int pr);
    wr(8'(8'h80 + i), {24'd0, 6'(pr), 1'b0, st});
    mSteer[i] = st;
    mPrio[i]  = pr;
  endtask

  // Reference selection per output, built from R4, R6 and R7.
  task automatic model(input int p, output bit f, output int n, output int pr);
    f = 0; n = 0; pr = 63;
    for (int i = 0; i < NL; i++) begin
      if ((hwIn[i] | mSwi[i]) && !mMask[i] && (int'(mSteer[i]) == p) &&
          (mThr == 255 || mPrio[i] < mThr)) begin
        if (!f || mPrio[i] < pr) begin f = 1; n = i; pr = mPrio[i]; end
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pat, clr;
    bit f; int n, pr;
    for (int i = 0; i < NL; i++) mPrio[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 / R2 / R5 / R7 reset state
    chk("R11 irq after reset", {31'd0, irqOut}, 32'd0);
    chk("R11 fiq after reset", {31'd0, fiqOut}, 32'd0);
    rd(bAddr(0, 1), d); chk("R2 mask reset bank0", d, 32'hFFFF_FFFF);
    rd(bAddr(1, 1), d); chk("R2 mask reset bank1", d, 32'hFFFF_FFFF);
    rd(8'h85, d);       chk("R5 level reset", d, 32'd0);
    rd(8'h05, d);       chk("R7 threshold reset", d, 32'h0000_00FF);

    // R2 / R1: every mask bit through clear and set
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 32; k++) begin
        wr(bAddr(b, 2), 32'd1 << k);
        rd(bAddr(b, 1), d); chk("R2 mask clear bit", d, ~(32'd1 << k));
        wr(bAddr(b, 3), 32'd1 << k);
        rd(bAddr(b, 3), d); chk("R2 mask set bit", d, 32'hFFFF_FFFF);
      end
    end

    // R3 / R4 soft-trigger set and clear, raw readback
    for (int t = 0; t < 8; t++) begin
      for (int b = 0; b < NB; b++) begin
        pat = rnd(); clr = rnd();
        wr(bAddr(b, 4), pat);
        mSwi[b*32 +: 32] = mSwi[b*32 +: 32] | pat;
        wr(bAddr(b, 5), clr);
        mSwi[b*32 +: 32] = mSwi[b*32 +: 32] & ~clr;
        rd(bAddr(b, 4), d); chk("R3 soft bits", d, mSwi[b*32 +: 32]);
        rd(bAddr(b, 0), d); chk("R4 raw word", d, hwIn[b*32 +: 32] | mSwi[b*32 +: 32]);
      end
    end

    // R6 / R7 / R8 / R4 / R1 pseudo-random selection sweep
    for (int t = 0; t < 120; t++) begin
      hwIn = {rnd(), rnd()};
      for (int b = 0; b < NB; b++) begin
        pat = rnd();
        wr(bAddr(b, 1), pat);               mMask[b*32 +: 32] = pat;
        wr(bAddr(b, 5), 32'hFFFF_FFFF);     mSwi[b*32 +: 32] = '0;
        pat = rnd() & rnd();
        wr(bAddr(b, 4), pat);               mSwi[b*32 +: 32] = pat;
      end
      for (int i = 0; i < NL; i++) begin
        pat = rnd();
        wrLevel(i, pat[8], (t % 3 == 0) ? int'(pat[1:0]) : int'(pat[5:0]));
      end
      case (t % 4)
        0, 3: mThr = 255;
        1:    mThr = int'(rnd() % 64);
        default: mThr = 0;
      endcase
      wr(8'h05, 32'(mThr));
      wr(8'h04, 32'd3);
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        model(p, f, n, pr);
        chk(p == 0 ? "R8 irq output" : "R8 fiq output",
            {31'd0, (p == 0) ? irqOut : fiqOut}, {31'd0, f});
        if (f) begin
          rd(8'(p), d);     chk("R6 winner number", d, 32'(n));
          rd(8'(p + 2), d); chk("R6 winner priority", d, 32'(pr));
        end
      end
      for (int b = 0; b < NB; b++) begin
        rd(bAddr(b, 6), d);
        chk("R4 pending normal", d, (hwIn[b*32 +: 32] | mSwi[b*32 +: 32]) & ~mMask[b*32 +: 32] & ~mSteer[b*32 +: 32]);
        rd(bAddr(b, 7), d);
        chk("R4 pending fast", d, (hwIn[b*32 +: 32] | mSwi[b*32 +: 32]) & ~mMask[b*32 +: 32] & mSteer[b*32 +: 32]);
      end
    end

    // Directed: clean slate
    hwIn = '0;
    for (int b = 0; b < NB; b++) begin
      wr(bAddr(b, 1), 32'hFFFF_FFFF);
      wr(bAddr(b, 5), 32'hFFFF_FFFF);
    end
    for (int i = 0; i < NL; i++) wrLevel(i, 1'b0, 0);
    wr(8'h05, 32'hFF);
    wr(8'h04, 32'd3);
    @(negedge clk);
    chk("R8 idle irq low", {31'd0, irqOut}, 32'd0);
    chk("R8 idle fiq low", {31'd0, fiqOut}, 32'd0);

    // R8 latency: line 10 by soft trigger, priority 5
    wrLevel(10, 1'b0, 5);
    wr(bAddr(0, 4), 32'd1 << 10);
    wr(bAddr(0, 2), 32'd1 << 10);
    chk("R8 one cycle latency", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    chk("R8 irq raised", {31'd0, irqOut}, 32'd1);
    rd(8'h00, d); chk("R8 number line 10", d, 32'd10);
    rd(8'h02, d); chk("R8 priority 5", d, 32'd5);

    // R9 hold: better line 40 (bank1 bit8) appears
    wrLevel(40, 1'b0, 0);
    hwIn[40] = 1'b1;
    wr(bAddr(1, 2), 32'd1 << 8);
    repeat (3) @(negedge clk);
    chk("R9 held output", {31'd0, irqOut}, 32'd1);
    rd(8'h00, d); chk("R9 held number", d, 32'd10);
    wr(8'h04, 32'd2);
    rd(8'h00, d); chk("R9 fast ack ignored by normal", d, 32'd10);
    chk("R9 fast ack keeps irq", {31'd0, irqOut}, 32'd1);
    wr(8'h04, 32'd1);
    chk("R9 release lowers irq", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    chk("R9 new winner raised", {31'd0, irqOut}, 32'd1);
    rd(8'h00, d); chk("R9 new winner 40", d, 32'd40);
    rd(8'h02, d); chk("R9 new priority 0", d, 32'd0);

    // R10 spurious by masking and by steering away
    wr(bAddr(1, 3), 32'd1 << 8);
    rd(8'h00, d); chk("R10 spurious number", d, 32'hFFFF_FFA8);
    rd(8'h02, d); chk("R10 spurious priority", d, 32'hFFFF_FFC0);
    chk("R10 output still held", {31'd0, irqOut}, 32'd1);
    wr(bAddr(1, 2), 32'd1 << 8);
    rd(8'h00, d); chk("R10 not spurious again", d, 32'd40);
    wrLevel(40, 1'b1, 0);
    rd(8'h00, d); chk("R10 spurious after steer", d, 32'hFFFF_FFA8);
    @(negedge clk);
    chk("R8 fast raised", {31'd0, fiqOut}, 32'd1);
    rd(8'h01, d); chk("R8 fast number 40", d, 32'd40);

    // R7 threshold on the normal output (line 10, priority 5)
    wr(8'h05, 32'd5);
    wr(8'h04, 32'd1);
    @(negedge clk);
    chk("R7 threshold 5 blocks priority 5", {31'd0, irqOut}, 32'd0);
    wr(8'h05, 32'd6);
    @(negedge clk);
    chk("R7 threshold 6 passes priority 5", {31'd0, irqOut}, 32'd1);
    rd(8'h00, d); chk("R7 number line 10", d, 32'd10);

    // R6 tie: lines 3 and 2 at equal priority, lower number wins
    wr(8'h05, 32'hFF);
    wrLevel(3, 1'b0, 1);
    wrLevel(2, 1'b0, 1);
    wr(bAddr(0, 4), 32'h0000_000C);
    wr(bAddr(0, 2), 32'h0000_000C);
    wr(8'h04, 32'd1);
    @(negedge clk);
    rd(8'h00, d); chk("R6 tie lower number", d, 32'd2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule